// File: doc/BRIEF.md
# I2C Slave Receive Controller

This block is an I2C bus slave that accepts bytes written by an external master. It synchronises the SCL and SDA lines into the system clock domain and finds start and stop conditions on the filtered copies. The first byte after a start is compared with a programmable 7-bit station address. On a match the block answers each frame with a host-selected acknowledge level, and it hands every received byte to a holding register that the host reads through a small register-style interface.

The address byte itself is placed in the holding register as a dummy read, so the host sees every frame of the transfer. When the host falls behind, the block holds SCL low after the eighth clock of the next byte until the holding register is read. Both bus outputs are open-drain enables: the block only pulls a line low or lets it go.

Top module: `i2c_rx_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) moves the block to the address phase; a stop (SDA rising while SCL is high) returns it to idle with both lines released, and clocked bytes seen while idle are not acknowledged and do not touch `rx_full`.
- R2: The block is selected only when the 7 upper bits of the first byte after a start equal `own_addr` and the lowest bit (R/W) is 0; otherwise SDA stays released for the acknowledge and the bus is ignored until the next start.
- R3: Bits are taken on SCL rising edges most significant bit first, so the first of the eight data clocks supplies bit 7 of `rx_data`.
- R4: A matching address frame loads `rx_data` with the address byte `{own_addr, 1'b0}` and sets `rx_full`.
- R5: Each data byte of a selected transfer is loaded into `rx_data` and sets `rx_full`; a one-cycle `rd` pulse clears `rx_full`.
- R6: During the ninth clock of a selected frame the block pulls SDA low when the latched acknowledge level is 0 and releases SDA when it is 1.
- R7: `ack_ctl` is latched at each start and at the falling edge of each ninth clock, so a change made within a frame governs the acknowledge of the next frame, not the current one.
- R8: If `rx_full` is still set at the falling edge of the eighth clock, SCL is held low until `rd` is pulsed; the new byte is then loaded, `rx_full` stays set and SCL is released.
- R9: While `rx_full` is set and no read occurs, `rx_data` does not change.
- R10: The bus outputs are pull-low enables only; both are 0 after reset and whenever the block is idle.
- R11: While `en` is 0 the block releases both lines, clears `rx_full` and does not answer any address.
- R12: A repeated start in the middle of a transfer returns the block to the address phase, where a new address byte is compared afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| own_addr | input | 7 | Station address |
| ack_ctl | input | 1 | Acknowledge level: 0 pulls SDA low (ACK), 1 releases (NACK) |
| rd | input | 1 | One-cycle host read strobe of `rx_data` |
| rx_data | output | 8 | Received byte holding register |
| rx_full | output | 1 | Holding register contains an unread byte |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |

## Verification
On every cycle the assertions check that a clock stretch only occurs while the holding register is full, that a read without a pending byte empties it, that the held byte is stable while unread, and that a disabled block lets go of both lines. Address comparison, bit ordering, the acknowledge level of each frame, the one-frame delay of an acknowledge change, the release after a stop or repeated start, and the loading of a stretched byte only show up in the bench's bus scenarios, where a modelled master with stretch-aware clocking drives random and directed transfers.

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave #(
  parameter int ADDR_W = 7,
  parameter int SYNC_N = 2,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_ctl,
  input  logic              rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} st_t;

  logic [SYNC_N-1:0] scl_s, sda_s;
  logic              scl_q, sda_q;
  logic              scl_r, sda_r;
  st_t               st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_lat, ack_drv, pend;

  assign scl_r = scl_s[SYNC_N-1];
  assign sda_r = sda_s[SYNC_N-1];

  wire start_c  = scl_q & scl_r & sda_q & ~sda_r;
  wire stop_c   = scl_q & scl_r & ~sda_q & sda_r;
  wire scl_rise = ~scl_q & scl_r;
  wire scl_fall = scl_q & ~scl_r;
  wire in_frame = (st == ST_ADDR) || (st == ST_DATA);
  wire addr_ok  = (shreg[BYTE_W-1:1] == own_addr) && !shreg[0];

  assign scl_pull = pend;
  assign sda_pull = ack_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_N-2:0], scl_i};
      sda_s <= {sda_s[SYNC_N-2:0], sda_i};
      scl_q <= scl_r;
      sda_q <= sda_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      ack_lat <= 1'b0;
      ack_drv <= 1'b0;
      pend    <= 1'b0;
    end else if (!en) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx_full <= 1'b0;
      ack_drv <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (rd) rx_full <= 1'b0;
      if (start_c) begin
        st      <= ST_ADDR;
        cnt     <= '0;
        pend    <= 1'b0;
        ack_drv <= 1'b0;
        ack_lat <= ack_ctl;
      end else if (stop_c) begin
        st      <= ST_IDLE;
        cnt     <= '0;
        pend    <= 1'b0;
        ack_drv <= 1'b0;
      end else begin
        if (pend && rd) begin
          rx_data <= shreg;
          rx_full <= 1'b1;
          pend    <= 1'b0;
          ack_drv <= ~ack_lat;
        end
        if (scl_rise && st != ST_IDLE) begin
          if (cnt < 4'(BYTE_W)) shreg <= {shreg[BYTE_W-2:0], sda_r};
          cnt <= cnt + 4'd1;
        end
        if (scl_fall && st != ST_IDLE) begin
          if (cnt == 4'(BYTE_W) && in_frame) begin
            if (st == ST_ADDR && !addr_ok) begin
              st <= ST_SKIP;
            end else if (rx_full && !rd) begin
              pend <= 1'b1;
            end else begin
              rx_data <= shreg;
              rx_full <= 1'b1;
              ack_drv <= ~ack_lat;
            end
          end else if (cnt == 4'(BYTE_W + 1)) begin
            cnt     <= '0;
            ack_drv <= 1'b0;
            ack_lat <= ack_ctl;
            if (st == ST_ADDR) st <= ST_DATA;
          end
        end
      end
    end
  end

endmodule

module i2c_rx_slave_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              rd,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_full,
  input logic              scl_pull,
  input logic              sda_pull
);

  a_r8_stretch_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> rx_full);

  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rd && rx_full && !scl_pull |=> !rx_full);

  a_r9_held_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rd |=> $stable(rx_data));

  a_r11_disabled_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull && !sda_pull && !rx_full);

  a_r8_stretch_ends_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull && rd && en |=> rx_full);

endmodule

bind i2c_rx_slave i2c_rx_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd(rd), .rx_data(rx_data),
  .rx_full(rx_full), .scl_pull(scl_pull), .sda_pull(sda_pull)
);

// File: tb/i2c_rx_slave_test.sv
module i2c_rx_slave_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] own_addr = 7'h00;
  logic       ack_ctl = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_pull, sda_pull;
  wire        scl_bus = scl_m & ~scl_pull;
  wire        sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0;
  localparam int Q = 10;

  always #10 clk = ~clk;

  i2c_rx_slave uut (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr), .ack_ctl(ack_ctl),
    .rd(rd), .rx_data(rx_data), .rx_full(rx_full), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(Q);
    scl_up(); wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(Q);
    scl_up(); wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_up(); wt(2*Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_up(); wt(Q);
    nack = sda_bus;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic host_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    wt(1);
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  initial begin
    wt(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic nk;
    logic [7:0] b, b2;
    int seed;
    seed = $urandom(32'd2024);
    own_addr = 7'($urandom);
    wt(5);
    rst_n = 1'b1;
    wt(2);
    chk("R10 reset rx_full", rx_full, 0);
    chk("R10 reset pulls", {scl_pull, sda_pull}, 0);
    en = 1'b1;

    // R2 R4 address match and dummy read
    i2c_start();
    send_byte(addr_byte(own_addr, 1'b0), nk);
    chk("R2 R6 address ack", nk, 0);
    chk("R4 rx_full after address", rx_full, 1);
    chk("R4 dummy byte", rx_data, addr_byte(own_addr, 1'b0));
    host_rd();
    chk("R5 read clears", rx_full, 0);

    // R3 R5 random data
    for (int k = 0; k < 6; k++) begin
      b = 8'($urandom);
      send_byte(b, nk);
      chk("R6 data ack", nk, 0);
      chk("R5 rx_full set", rx_full, 1);
      chk("R3 byte MSB first", rx_data, b);
      host_rd();
    end

    // R7 ack change inside a frame
    b = 8'($urandom);
    fork
      send_byte(b, nk);
      begin wt(100); ack_ctl = 1'b1; end
    join
    chk("R7 current frame keeps ack", nk, 0);
    chk("R3 byte", rx_data, b);
    host_rd();
    send_byte(8'h5A, nk);
    chk("R6 R7 next frame nack", nk, 1);
    host_rd();
    ack_ctl = 1'b0;
    send_byte(8'hC3, nk);
    chk("R7 frame latched before change nacks", nk, 1);
    host_rd();
    send_byte(8'h3C, nk);
    chk("R7 ack restored", nk, 0);
    chk("R5 byte after nack frames", rx_data, 8'h3C);
    host_rd();

    // R1 stop returns idle
    i2c_stop();
    wt(5);
    chk("R1 R10 pulls after stop", {scl_pull, sda_pull}, 0);
    send_byte(8'hA5, nk);
    chk("R1 idle no ack", nk, 1);
    chk("R1 idle no rx_full", rx_full, 0);

    // R2 wrong address and read bit
    i2c_start();
    send_byte(addr_byte(own_addr ^ 7'h01, 1'b0), nk);
    chk("R2 wrong address nack", nk, 1);
    chk("R2 wrong address no rx_full", rx_full, 0);
    send_byte(8'h00, nk);
    chk("R2 ignored data nack", nk, 1);
    chk("R2 ignored data no rx_full", rx_full, 0);
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(own_addr, 1'b1), nk);
    chk("R2 read bit nack", nk, 1);
    chk("R2 read bit no rx_full", rx_full, 0);
    i2c_stop();

    // R8 R9 clock stretch
    i2c_start();
    send_byte(addr_byte(own_addr, 1'b0), nk);
    host_rd();
    b = 8'($urandom);
    b2 = 8'($urandom);
    send_byte(b, nk);
    fork
      send_byte(b2, nk);
      begin
        while (!scl_pull) @(negedge clk);
        wt(300);
        chk("R8 scl held low", scl_pull, 1);
        chk("R9 held byte unchanged", rx_data, b);
        chk("R8 still full", rx_full, 1);
        host_rd();
        chk("R8 scl released", scl_pull, 0);
      end
    join
    chk("R8 stretched byte ack", nk, 0);
    chk("R8 stretched byte loaded", rx_data, b2);
    chk("R8 full after stretched load", rx_full, 1);
    host_rd();

    // R12 repeated start
    send_byte(8'h77, nk);
    host_rd();
    i2c_start();
    send_byte(addr_byte(own_addr ^ 7'h40, 1'b0), nk);
    chk("R12 rstart wrong address nack", nk, 1);
    i2c_start();
    send_byte(addr_byte(own_addr, 1'b0), nk);
    chk("R12 rstart address ack", nk, 0);
    chk("R12 R4 dummy after rstart", rx_data, addr_byte(own_addr, 1'b0));
    chk("R12 full after rstart", rx_full, 1);

    // R11 disable
    en = 1'b0;
    wt(2);
    chk("R11 disable clears full", rx_full, 0);
    chk("R11 disable releases", {scl_pull, sda_pull}, 0);
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(own_addr, 1'b0), nk);
    chk("R11 disabled no ack", nk, 1);
    chk("R11 disabled no rx_full", rx_full, 0);
    i2c_stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule